// File: doc/BRIEF.md
# Per-Channel DMA Register Window Translator

This block is an I/O-space slave placed in front of a pair of cascaded legacy DMA controllers. It gives each of the eight DMA channels a private 16-byte register window. Software can then program a channel without touching shared controller registers or the byte-pointer flip-flop. Each byte access that lands in a window becomes one or more cycles on a byte-wide downstream port. That port carries a channel number, a register kind, a register address and data, with write and read strobes and a ready handshake.

Two base registers each place a group of four consecutive channel windows. The first group serves channels 0 to 3 and the second serves channels 4 to 7. Window offsets are rewritten as follows:
- Offsets for the base/current address and count go to per-channel address and count registers.
- The page offset goes to the legacy page register of that channel.
- Command, request, single-mask, mode and master-clear offsets go unchanged to the controller that owns the channel.
- A mask-by-channel offset folds the channel number into a single-mask command.
- A clear-all offset expands into a burst of four single-mask writes.

A host access is accepted only while the block is idle. The host sees a one-cycle completion pulse once the last downstream cycle has been acknowledged.

Top module: `ddma_xlate`

## Requirements
- R1: The window of channel c in group g (c = 4g + j, j = 0..3) covers the 16 addresses from base_g + 0x10·j upward. A host address decoded in a window drives `io_hit` and, when accepted, drives `dc_chan` = c. Addresses outside every window leave `io_hit` low. If both groups overlap, group 0 wins.
- R2: For each group, the base is built from a high config byte, kept whole, and a low config byte, of which only bits 7:6 are kept. Config codes: 0 = group 0 low, 1 = group 0 high, 2 = group 1 low, 3 = group 1 high, 4 = enable (bit 0). Nothing is decoded unless enable is set and the base is nonzero. Reset clears all bases and the enable.
- R3: A write to offset 0x00, 0x01, 0x04 or 0x05 issues one downstream write carrying the host data unchanged and `dc_addr` = the offset. Offsets 0x00 and 0x01 use `dc_kind` 0 (address, loading base and current). Offsets 0x04 and 0x05 use `dc_kind` 1 (count). `dc_kind` 2 is page and 3 is controller register.
- R4: A write to offset 0x02 issues one page write (kind 2). Its `dc_addr` is 0x80 + idx for channels 0 to 3 and 0x88 + idx for channels 4 to 7, where idx is 7, 3, 1, 2 for channel mod 4 = 0, 1, 2, 3.
- R5: A write to offset 0x08, 0x09, 0x0A, 0x0B or 0x0D issues one controller write (kind 3). Its `dc_addr` is the controller base plus the offset and its data is unchanged. The controller base is 0x00 for channels 0 to 3 and 0xC0 for channels 4 to 7.
- R6: A write of v to offset 0x0F issues one kind-3 write to controller base + 0x0A with data (v << 2) | (channel mod 4), truncated to 8 bits.
- R7: A write to offset 0x0E issues exactly four kind-3 writes to controller base + 0x0A, with data 0, 1, 2, 3 in that order.
- R8: Reads at offsets 0x00 and 0x01 return the downstream kind-0 read data and reads at 0x04 and 0x05 return kind-1 read data, each with `dc_addr` = offset. A read at 0x02 returns the page read at the R4 address. A read at 0x09 returns the controller read at base + 0x08 (status).
- R9: A read at any other offset returns 0xFF and a write at any other offset does nothing. Neither starts a downstream cycle, and both still complete.
- R10: `io_ready` is low from acceptance until completion. `io_done` pulses for exactly one cycle after the last downstream acknowledge, and `io_ready` is high in the cycle that follows.
- R11: At most one downstream strobe is active at a time. A strobe and its channel, kind, address and data stay stable until `dc_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Config byte write strobe |
| cfg_addr | input | 3 | Config byte select (R2 codes) |
| cfg_wdata | input | 8 | Config write data |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write request |
| io_rd | input | 1 | Host read request |
| io_wdata | input | 8 | Host write data |
| io_hit | output | 1 | Address falls in an enabled window |
| io_ready | output | 1 | Block idle, can accept a request |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 8 | Read result, valid with io_done |
| dc_wr | output | 1 | Downstream write strobe |
| dc_rd | output | 1 | Downstream read strobe |
| dc_chan | output | 3 | Downstream channel number |
| dc_kind | output | 2 | Downstream register kind |
| dc_addr | output | 8 | Downstream register address |
| dc_wdata | output | 8 | Downstream write data |
| dc_rdata | input | 8 | Downstream read data |
| dc_ready | input | 1 | Downstream cycle acknowledge |

## Verification
The checker watches the rules that hold in every cycle:
- downstream strobes never overlap and hold stable until acknowledged;
- the host side stays not-ready while any downstream strobe is active;
- completion is followed by readiness;
- page and controller addresses always fall in the ranges their channel group allows.

Only the directed scenarios can show that each offset reaches the right kind, address and data, and that the clear-all burst carries data 0 to 3 in order. They also cover the open-bus value, base-byte masking, enable gating and group placement, which are all relations between the programmed configuration and a specific access.

// File: rtl/ddma_pkg.sv
package ddma_pkg;

   typedef enum logic [1:0] {
      DK_ADDR = 2'd0,
      DK_CNT  = 2'd1,
      DK_PAGE = 2'd2,
      DK_CTRL = 2'd3
   } dk_e;

   typedef struct packed {
      logic       valid;
      logic       burst;
      dk_e        kind;
      logic [7:0] addr;
      logic [7:0] data;
   } dop_t;

   localparam logic [7:0] OPEN_BUS = 8'hFF;

   function automatic logic [7:0] page_idx(input logic [1:0] rel);
      case (rel)
         2'd0:    page_idx = 8'd7;
         2'd1:    page_idx = 8'd3;
         2'd2:    page_idx = 8'd1;
         default: page_idx = 8'd2;
      endcase
   endfunction

endpackage

// File: rtl/ddma_cfg_regs.sv
module ddma_cfg_regs #(
   parameter int NUM_GROUPS = 2,
   parameter int AW         = 16,
   parameter int KEEP_LSB   = 6,
   parameter int CFG_AW     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [7:0]               cfg_wdata,
   output logic [NUM_GROUPS*AW-1:0] base_flat,
   output logic                     enable
);
   localparam int EN_CODE = 2 * NUM_GROUPS;
   localparam logic [7:0] LO_MASK = 8'hFF << KEEP_LSB;

   if (AW != 16) begin : g_bad_aw
      $error("ddma_cfg_regs: AW must be 16");
   end
   if (KEEP_LSB < 1 || KEEP_LSB > 7) begin : g_bad_keep
      $error("ddma_cfg_regs: KEEP_LSB out of range");
   end
   if ((1 << CFG_AW) <= EN_CODE) begin : g_bad_cfgaw
      $error("ddma_cfg_regs: CFG_AW too narrow");
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [7:0] lo_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= 8'h00;
            hi_q <= 8'h00;
         end else if (cfg_wr) begin
            if (cfg_addr == CFG_AW'(2 * g))
               lo_q <= cfg_wdata & LO_MASK;
            if (cfg_addr == CFG_AW'(2 * g + 1))
               hi_q <= cfg_wdata;
         end
      end
      assign base_flat[g*AW +: AW] = {hi_q, lo_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enable <= 1'b0;
      else if (cfg_wr && cfg_addr == CFG_AW'(EN_CODE))
         enable <= cfg_wdata[0];
   end

endmodule

// File: rtl/ddma_win_decode.sv
module ddma_win_decode #(
   parameter int NUM_GROUPS = 2,
   parameter int CH_PER_GRP = 4,
   parameter int WIN_BYTES  = 16,
   parameter int AW         = 16,
   parameter int CH_W       = $clog2(NUM_GROUPS * CH_PER_GRP),
   parameter int OFF_W      = $clog2(WIN_BYTES)
) (
   input  logic [NUM_GROUPS*AW-1:0] base_flat,
   input  logic                     enable,
   input  logic [AW-1:0]            io_addr,
   output logic                     hit,
   output logic [CH_W-1:0]          chan,
   output logic [OFF_W-1:0]         off
);
   localparam int SPAN_LSB = $clog2(CH_PER_GRP * WIN_BYTES);
   localparam int REL_W    = $clog2(CH_PER_GRP);

   if ((1 << OFF_W) != WIN_BYTES) begin : g_bad_win
      $error("ddma_win_decode: WIN_BYTES must be a power of two");
   end
   if ((1 << REL_W) != CH_PER_GRP) begin : g_bad_cpg
      $error("ddma_win_decode: CH_PER_GRP must be a power of two");
   end

   logic [NUM_GROUPS-1:0] grp_hit;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cmp
      logic [AW-1:0] b;
      assign b = base_flat[g*AW +: AW];
      assign grp_hit[g] = enable && (b != '0) &&
                          (io_addr[AW-1:SPAN_LSB] == b[AW-1:SPAN_LSB]);
   end

   logic [REL_W-1:0] rel;
   assign rel = io_addr[SPAN_LSB-1:OFF_W];
   assign off = io_addr[OFF_W-1:0];

   always_comb begin
      hit  = 1'b0;
      chan = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (grp_hit[g]) begin
            hit  = 1'b1;
            chan = CH_W'(g * CH_PER_GRP) + CH_W'(rel);
         end
      end
   end

endmodule

// File: rtl/ddma_op_map.sv
module ddma_op_map
   import ddma_pkg::*;
#(
   parameter int CH_W  = 3,
   parameter int OFF_W = 4
) (
   input  logic [CH_W-1:0]  chan,
   input  logic [OFF_W-1:0] off,
   input  logic             is_wr,
   input  logic [7:0]       wdata,
   output dop_t             op
);
   if (CH_W != 3 || OFF_W != 4) begin : g_bad
      $error("ddma_op_map: mapping defined for 8 channels of 16 bytes");
   end

   logic       upper;
   logic [1:0] rel;
   logic [7:0] ctl_base, pg_addr, off8;

   assign upper    = chan[CH_W-1];
   assign rel      = chan[1:0];
   assign ctl_base = upper ? 8'hC0 : 8'h00;
   assign pg_addr  = (upper ? 8'h88 : 8'h80) + page_idx(rel);
   assign off8     = {4'h0, off};

   always_comb begin
      op       = '0;
      op.kind  = DK_ADDR;
      op.data  = wdata;
      if (is_wr) begin
         case (off)
            4'h0, 4'h1: begin
               op.valid = 1'b1; op.kind = DK_ADDR; op.addr = off8;
            end
            4'h4, 4'h5: begin
               op.valid = 1'b1; op.kind = DK_CNT; op.addr = off8;
            end
            4'h2: begin
               op.valid = 1'b1; op.kind = DK_PAGE; op.addr = pg_addr;
            end
            4'h8, 4'h9, 4'hA, 4'hB, 4'hD: begin
               op.valid = 1'b1; op.kind = DK_CTRL; op.addr = ctl_base | off8;
            end
            4'hE: begin
               op.valid = 1'b1; op.kind = DK_CTRL; op.burst = 1'b1;
               op.addr  = ctl_base | 8'h0A; op.data = 8'h00;
            end
            4'hF: begin
               op.valid = 1'b1; op.kind = DK_CTRL;
               op.addr  = ctl_base | 8'h0A; op.data = {wdata[5:0], rel};
            end
            default: op.valid = 1'b0;
         endcase
      end else begin
         op.data = 8'h00;
         case (off)
            4'h0, 4'h1: begin
               op.valid = 1'b1; op.kind = DK_ADDR; op.addr = off8;
            end
            4'h4, 4'h5: begin
               op.valid = 1'b1; op.kind = DK_CNT; op.addr = off8;
            end
            4'h2: begin
               op.valid = 1'b1; op.kind = DK_PAGE; op.addr = pg_addr;
            end
            4'h9: begin
               op.valid = 1'b1; op.kind = DK_CTRL; op.addr = ctl_base | 8'h08;
            end
            default: op.valid = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/ddma_seq.sv
module ddma_seq
   import ddma_pkg::*;
#(
   parameter int CH_W      = 3,
   parameter int BURST_LEN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_wr,
   input  logic [CH_W-1:0] start_chan,
   input  dop_t            start_op,
   output logic            io_ready,
   output logic            io_done,
   output logic [7:0]      io_rdata,
   output logic            dc_wr,
   output logic            dc_rd,
   output logic [CH_W-1:0] dc_chan,
   output logic [1:0]      dc_kind,
   output logic [7:0]      dc_addr,
   output logic [7:0]      dc_wdata,
   input  logic [7:0]      dc_rdata,
   input  logic            dc_ready
);
   localparam int LEFT_W = $clog2(BURST_LEN + 1);

   if (BURST_LEN < 1) begin : g_bad
      $error("ddma_seq: BURST_LEN must be at least 1");
   end

   typedef enum logic [1:0] {S_IDLE, S_BUS, S_FIN} st_e;

   st_e               st_q;
   logic              wr_q;
   logic [CH_W-1:0]   chan_q;
   dk_e               kind_q;
   logic [7:0]        addr_q, data_q, rdata_q;
   logic [LEFT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         wr_q    <= 1'b0;
         chan_q  <= '0;
         kind_q  <= DK_ADDR;
         addr_q  <= 8'h00;
         data_q  <= 8'h00;
         rdata_q <= OPEN_BUS;
         left_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               wr_q   <= start_wr;
               chan_q <= start_chan;
               kind_q <= start_op.kind;
               addr_q <= start_op.addr;
               data_q <= start_op.data;
               left_q <= start_op.burst ? LEFT_W'(BURST_LEN) : LEFT_W'(1);
               if (start_op.valid) begin
                  st_q <= S_BUS;
               end else begin
                  rdata_q <= OPEN_BUS;
                  st_q    <= S_FIN;
               end
            end
            S_BUS: if (dc_ready) begin
               if (!wr_q)
                  rdata_q <= dc_rdata;
               if (left_q == LEFT_W'(1)) begin
                  st_q <= S_FIN;
               end else begin
                  left_q <= left_q - LEFT_W'(1);
                  data_q <= data_q + 8'd1;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign io_ready = (st_q == S_IDLE);
   assign io_done  = (st_q == S_FIN);
   assign io_rdata = rdata_q;
   assign dc_wr    = (st_q == S_BUS) &&  wr_q;
   assign dc_rd    = (st_q == S_BUS) && !wr_q;
   assign dc_chan  = chan_q;
   assign dc_kind  = kind_q;
   assign dc_addr  = addr_q;
   assign dc_wdata = data_q;

endmodule

// File: rtl/ddma_xlate.sv
module ddma_xlate
   import ddma_pkg::*;
#(
   parameter int NUM_GROUPS = 2,
   parameter int CH_PER_GRP = 4,
   parameter int WIN_BYTES  = 16,
   parameter int AW         = 16,
   parameter int BURST_LEN  = 4,
   parameter int CFG_AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [AW-1:0]     io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic              io_hit,
   output logic              io_ready,
   output logic              io_done,
   output logic [7:0]        io_rdata,
   output logic              dc_wr,
   output logic              dc_rd,
   output logic [2:0]        dc_chan,
   output logic [1:0]        dc_kind,
   output logic [7:0]        dc_addr,
   output logic [7:0]        dc_wdata,
   input  logic [7:0]        dc_rdata,
   input  logic              dc_ready
);
   localparam int CH_W     = $clog2(NUM_GROUPS * CH_PER_GRP);
   localparam int OFF_W    = $clog2(WIN_BYTES);
   localparam int SPAN_LSB = $clog2(CH_PER_GRP * WIN_BYTES);

   if (CH_W != 3) begin : g_bad_ch
      $error("ddma_xlate: port widths assume eight channels");
   end

   logic [NUM_GROUPS*AW-1:0] base_flat;
   logic                     enable;
   logic                     hit;
   logic [CH_W-1:0]          chan;
   logic [OFF_W-1:0]         off;
   dop_t                     op;
   logic                     start;

   ddma_cfg_regs #(
      .NUM_GROUPS(NUM_GROUPS), .AW(AW), .KEEP_LSB(SPAN_LSB), .CFG_AW(CFG_AW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .base_flat(base_flat), .enable(enable)
   );

   ddma_win_decode #(
      .NUM_GROUPS(NUM_GROUPS), .CH_PER_GRP(CH_PER_GRP),
      .WIN_BYTES(WIN_BYTES), .AW(AW), .CH_W(CH_W), .OFF_W(OFF_W)
   ) u_dec (
      .base_flat(base_flat), .enable(enable), .io_addr(io_addr),
      .hit(hit), .chan(chan), .off(off)
   );

   ddma_op_map #(.CH_W(CH_W), .OFF_W(OFF_W)) u_map (
      .chan(chan), .off(off), .is_wr(io_wr), .wdata(io_wdata), .op(op)
   );

   assign start  = (io_wr || io_rd) && hit && io_ready;
   assign io_hit = hit;

   ddma_seq #(.CH_W(CH_W), .BURST_LEN(BURST_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_wr(io_wr),
      .start_chan(chan), .start_op(op),
      .io_ready(io_ready), .io_done(io_done), .io_rdata(io_rdata),
      .dc_wr(dc_wr), .dc_rd(dc_rd), .dc_chan(dc_chan), .dc_kind(dc_kind),
      .dc_addr(dc_addr), .dc_wdata(dc_wdata), .dc_rdata(dc_rdata),
      .dc_ready(dc_ready)
   );

endmodule

// File: rtl/ddma_xlate_chk.sv
module ddma_xlate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       io_ready,
   input logic       io_done,
   input logic       dc_wr,
   input logic       dc_rd,
   input logic [2:0] dc_chan,
   input logic [1:0] dc_kind,
   input logic [7:0] dc_addr,
   input logic [7:0] dc_wdata,
   input logic       dc_ready
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dc_wr && dc_rd)); // R11

   AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((dc_wr || dc_rd) && !dc_ready) |=> ((dc_wr || dc_rd) && $stable(dc_addr)
      && $stable(dc_kind) && $stable(dc_chan) && $stable(dc_wdata))); // R11

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_wr || dc_rd || io_done) |-> !io_ready); // R10

   AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      io_done |=> (io_ready && !io_done)); // R10

   AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((dc_wr || dc_rd) && dc_kind == 2'd2) |->
      (dc_addr[7:4] == 4'h8 && dc_addr[3] == dc_chan[2])); // R4

   AST_CTRL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((dc_wr || dc_rd) && dc_kind == 2'd3) |->
      (dc_addr[7:6] == {2{dc_chan[2]}} && dc_addr[5:4] == 2'b00)); // R5

endmodule

bind ddma_xlate ddma_xlate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .io_ready(io_ready), .io_done(io_done),
   .dc_wr(dc_wr), .dc_rd(dc_rd), .dc_chan(dc_chan), .dc_kind(dc_kind),
   .dc_addr(dc_addr), .dc_wdata(dc_wdata), .dc_ready(dc_ready)
);

// File: tb/ddma_xlate_test.sv
module ddma_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic        io_hit, io_ready, io_done;
   logic [7:0]  io_rdata;
   logic        dc_wr, dc_rd;
   logic [2:0]  dc_chan;
   logic [1:0]  dc_kind;
   logic [7:0]  dc_addr, dc_wdata, dc_rdata;
   logic        dc_ready = 1'b0;

   always #5 clk = ~clk;

   ddma_xlate uut (.*);

   // Downstream model: read data derived from address and kind.
   assign dc_rdata = dc_addr ^ {6'b0, dc_kind} ^ 8'hA5;
   always @(posedge clk) dc_ready <= (dc_wr || dc_rd) && !dc_ready;

   int vecs = 0, errs = 0, busy_bad = 0;
   int n_log = 0;
   logic [2:0] lg_chan [16];
   logic [1:0] lg_kind [16];
   logic [7:0] lg_addr [16];
   logic [7:0] lg_data [16];

   always @(negedge clk) begin
      if ((dc_wr || dc_rd) && dc_ready && n_log < 16) begin
         lg_chan[n_log] = dc_chan;
         lg_kind[n_log] = dc_kind;
         lg_addr[n_log] = dc_addr;
         lg_data[n_log] = dc_wdata;
         n_log = n_log + 1;
      end
      if ((dc_wr || dc_rd) && io_ready) busy_bad = busy_bad + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Issue one host access; returns completion flag and read data.
   task automatic host(input logic [15:0] a, input logic wr, input logic [7:0] d,
                       output logic done, output logic [7:0] rd);
      done = 1'b0; rd = 8'h00;
      n_log = 0;
      @(negedge clk);
      io_addr = a; io_wr = wr; io_rd = !wr; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      for (int i = 0; i < 40 && !done; i++) begin
         if (io_done) begin
            done = 1'b1; rd = io_rdata;
            @(negedge clk);
            chk("R10 done single pulse", io_done, 0);
            chk("R10 ready after done", io_ready, 1);
         end else begin
            @(negedge clk);
         end
      end
   endtask

   task automatic chk_entry(input string tag, input int i, input int ch,
                            input int k, input int ad, input int da);
      chk({tag, " chan"}, lg_chan[i], ch);
      chk({tag, " kind"}, lg_kind[i], k);
      chk({tag, " addr"}, lg_addr[i], ad);
      chk({tag, " data"}, lg_data[i], da);
   endtask

   logic dn;
   logic [7:0] rv;

   task automatic t_reset;
      @(negedge clk);
      io_addr = 16'h12C0;
      #1;
      chk("R2 reset no hit", io_hit, 0);
      chk("R10 reset ready", io_ready, 1);
      chk("R11 reset no strobe", dc_wr | dc_rd, 0);
   endtask

   task automatic t_config;
      cfg(3'd0, 8'hFF); cfg(3'd1, 8'h12);
      cfg(3'd2, 8'h40); cfg(3'd3, 8'h34);
      @(negedge clk); io_addr = 16'h12C0; #1;
      chk("R2 not enabled no hit", io_hit, 0);
      cfg(3'd4, 8'h01);
      @(negedge clk); io_addr = 16'h12C0; #1;
      chk("R2 window hit base masked", io_hit, 1);
      io_addr = 16'h12FF; #1;
      chk("R1 last window byte", io_hit, 1);
      io_addr = 16'h1300; #1;
      chk("R1 past group span", io_hit, 0);
      io_addr = 16'h12BF; #1;
      chk("R1 below base", io_hit, 0);
   endtask

   task automatic t_addr_cnt;
      host(16'h12D0, 1'b1, 8'h3C, dn, rv);
      chk("R3 addr write done", dn, 1);
      chk("R3 addr write count", n_log, 1);
      chk_entry("R3 ch1 addr lo", 0, 1, 0, 8'h00, 8'h3C);
      host(16'h3475, 1'b1, 8'h81, dn, rv);
      chk("R3 count write count", n_log, 1);
      chk_entry("R1 R3 ch7 count hi", 0, 7, 1, 8'h05, 8'h81);
   endtask

   task automatic t_page;
      host(16'h12D2, 1'b1, 8'h11, dn, rv);
      chk_entry("R4 ch1 page", 0, 1, 2, 8'h83, 8'h11);
      host(16'h3442, 1'b1, 8'h22, dn, rv);
      chk_entry("R4 ch4 page", 0, 4, 2, 8'h8F, 8'h22);
      host(16'h3462, 1'b1, 8'h33, dn, rv);
      chk_entry("R4 ch6 page", 0, 6, 2, 8'h89, 8'h33);
   endtask

   task automatic t_ctrl;
      host(16'h12EB, 1'b1, 8'h56, dn, rv);
      chk_entry("R5 ch2 mode", 0, 2, 3, 8'h0B, 8'h56);
      host(16'h3458, 1'b1, 8'h9A, dn, rv);
      chk_entry("R5 ch5 command", 0, 5, 3, 8'hC8, 8'h9A);
      host(16'h12CD, 1'b1, 8'h00, dn, rv);
      chk_entry("R5 ch0 master clear", 0, 0, 3, 8'h0D, 8'h00);
   endtask

   task automatic t_single_mask;
      host(16'h346F, 1'b1, 8'h01, dn, rv);
      chk("R6 one write", n_log, 1);
      chk_entry("R6 ch6 mask", 0, 6, 3, 8'hCA, 8'h06);
      host(16'h12FF, 1'b1, 8'h41, dn, rv);
      chk_entry("R6 ch3 mask truncated", 0, 3, 3, 8'h0A, 8'h07);
   endtask

   task automatic t_burst_mask;
      busy_bad = 0;
      host(16'h345E, 1'b1, 8'hEE, dn, rv);
      chk("R7 burst done", dn, 1);
      chk("R7 four writes", n_log, 4);
      for (int i = 0; i < 4; i++)
         chk_entry("R7 burst entry", i, 5, 3, 8'hCA, i);
      chk("R10 not ready while busy", busy_bad, 0);
   endtask

   task automatic t_reads;
      host(16'h12F1, 1'b0, 8'h00, dn, rv);
      chk("R8 addr hi read", rv, 8'h01 ^ 8'hA5);
      chk_entry("R8 addr hi read cycle", 0, 3, 0, 8'h01, 8'h00);
      host(16'h12C4, 1'b0, 8'h00, dn, rv);
      chk("R8 count lo read", rv, 8'h04 ^ 8'h01 ^ 8'hA5);
      host(16'h3442, 1'b0, 8'h00, dn, rv);
      chk("R8 page read", rv, 8'h8F ^ 8'h02 ^ 8'hA5);
      host(16'h3459, 1'b0, 8'h00, dn, rv);
      chk("R8 status read", rv, 8'hC8 ^ 8'h03 ^ 8'hA5);
      chk_entry("R8 status cycle", 0, 5, 3, 8'hC8, 8'h00);
   endtask

   task automatic t_unlisted;
      host(16'h12C3, 1'b0, 8'h00, dn, rv);
      chk("R9 open bus done", dn, 1);
      chk("R9 open bus value", rv, 8'hFF);
      chk("R9 open bus no cycle", n_log, 0);
      host(16'h12CC, 1'b1, 8'h77, dn, rv);
      chk("R9 ignored write done", dn, 1);
      chk("R9 ignored write no cycle", n_log, 0);
      host(16'h12C8, 1'b0, 8'h00, dn, rv);
      chk("R9 write-only offset read", rv, 8'hFF);
   endtask

   task automatic t_gating;
      cfg(3'd0, 8'h3F);
      @(negedge clk); io_addr = 16'h1200; #1;
      chk("R2 low bits dropped", io_hit, 1);
      cfg(3'd2, 8'h00); cfg(3'd3, 8'h00);
      @(negedge clk); io_addr = 16'h0010; #1;
      chk("R2 zero base no hit", io_hit, 0);
      cfg(3'd4, 8'h00);
      host(16'h1202, 1'b1, 8'h55, dn, rv);
      chk("R2 disabled no completion", dn, 0);
      chk("R2 disabled no cycle", n_log, 0);
   endtask

   bit fin = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_addr_cnt();
      t_page();
      t_ctrl();
      t_single_mask();
      t_burst_mask();
      t_reads();
      t_unlisted();
      t_gating();
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         vecs++; errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule